// File: doc/BRIEF.md
# Soft Power and Reset Sequencer

This always-on block owns the enable of the main DC/DC converter, the active-low reset line of the system and the power indicator. It gives the system a soft power button. A short press turns the supply on from the off state. Holding the button for a long time forces the supply off, and that override beats anything the host does. The host can also turn the supply on or off by writing a one-bit power control register.

Both buttons pass through a two-flop synchroniser and a debouncer that counts prescaler ticks. Every decision uses the debounced levels. The system reset stays asserted while the supply is off, while the rails-good input is low, or while the reset button is held. After all three conditions clear, reset stays asserted for a fixed hold time before it is released. The host can read the debounced power button through a status byte and gets a one-cycle event pulse whenever that state changes. The reset button cannot be seen through the status byte.

The prescaler produces one tick every `TICK_DIV` clock cycles, nominally 1 ms. The debounce time, the reset hold time and the long-press time are each a parameter counted in ticks. Their nominal values are 20, 100 and 3000.

Top module: `softpwr_seq`

## Requirements
- R1: While `rst_n` is low, `dcdc_en`, `sys_reset_n`, `pwr_led`, `btn_status` and `btn_change` are all 0.
- R2: A button level that lasts fewer than `DEBOUNCE_TICKS` ticks has no effect on any output.
- R3: When the supply is off, a debounced rising edge of the power button turns `dcdc_en` on.
- R4: A host write with `host_wr_en` high sets `dcdc_en` to `host_wr_data[0]` on the next cycle. Bits 7 to 1 of the data are ignored. Writing 0 powers the system down.
- R5: Once the debounced power button has been held for `LONG_PRESS_TICKS` ticks, `dcdc_en` goes to 0. It stays at 0 while the button remains held, even if the host writes 1 during that time.
- R6: `sys_reset_n` rises only after `dcdc_en` and `rails_good` have both been high, and the debounced reset button low, for `RESET_HOLD_TICKS` consecutive ticks.
- R7: If `rails_good` or `dcdc_en` is low in a cycle, `sys_reset_n` is low in the next cycle.
- R8: A debounced press of the reset button asserts `sys_reset_n` low. After the button is released, the full hold time runs again before reset is released.
- R9: `btn_status[0]` is the debounced power button level, with 1 meaning pressed. Bits 7 to 1 read 0. The reset button never appears in `btn_status`.
- R10: `btn_change` pulses high for exactly one cycle on each debounced change of the power button, on both the press and the release.
- R11: `pwr_led` equals `dcdc_en` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| pwr_btn_raw | input | 1 | Raw power button, 1 = pressed |
| rst_btn_raw | input | 1 | Raw reset button, 1 = pressed |
| rails_good | input | 1 | All power rails are within range |
| host_wr_en | input | 1 | One-cycle write strobe for the power control register |
| host_wr_data | input | 8 | Write data; bit 0 = supply on |
| dcdc_en | output | 1 | Main DC/DC converter enable |
| sys_reset_n | output | 1 | Active-low system reset |
| pwr_led | output | 1 | Power indicator |
| btn_status | output | 8 | Button status byte; bit 0 = debounced power button |
| btn_change | output | 1 | One-cycle pulse when the debounced power button changes |

## Verification
The hardest condition to reach from the ports is the long-press override while the host fights it. The power button has to pass the debouncer and then stay held for the whole long-press window. Only then can a host write of 1 be shown to lose, and the supply then has to be shown still off once the button is let go. The bench shrinks the prescaler and the tick limits through parameters so that the window is tens of cycles long. It then holds the raw button well past the worst-case window, issues a write while the button is still held, and checks the enable before and after the release. Glitches shorter than the debounce time and the interplay between the reset button and the reset hold time are driven directly. A constrained-random phase then mixes host writes with rails-good dropouts.

// File: rtl/softpwr_pkg.sv
package softpwr_pkg;
   localparam int NUM_BTN = 2;
   localparam int BTN_PWR = 0;
   localparam int BTN_RST = 1;

   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit + 1) : 1;
   endfunction
endpackage

// File: rtl/softpwr_tick.sv
module softpwr_tick #(
   parameter int DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = softpwr_pkg::cnt_width(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   generate
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) cnt <= '0;
            else        cnt <= '0;
      end else begin : g_div
         assign tick = (cnt == LAST);
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)    cnt <= '0;
            else if (tick) cnt <= '0;
            else           cnt <= cnt + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/softpwr_debounce.sv
module softpwr_debounce #(
   parameter int TICKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw,
   output logic level
);
   localparam int CW = softpwr_pkg::cnt_width(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [1:0]    sync;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync  <= '0;
         cnt   <= '0;
         level <= 1'b0;
      end else begin
         sync <= {sync[0], raw};
         if (sync[1] == level) begin
            cnt <= '0;
         end else if (tick) begin
            if (cnt == LAST) begin
               level <= sync[1];
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/softpwr_timer.sv
module softpwr_timer #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   output logic done
);
   localparam int CW = softpwr_pkg::cnt_width(LIMIT);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] cnt;

   assign done = (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                cnt <= '0;
      else if (!run)             cnt <= '0;
      else if (tick && !done)    cnt <= cnt + 1'b1;
endmodule

// File: rtl/softpwr_seq.sv
module softpwr_seq #(
   parameter int TICK_DIV         = 50000,
   parameter int DEBOUNCE_TICKS   = 20,
   parameter int RESET_HOLD_TICKS = 100,
   parameter int LONG_PRESS_TICKS = 3000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_btn_raw,
   input  logic       rst_btn_raw,
   input  logic       rails_good,
   input  logic       host_wr_en,
   input  logic [7:0] host_wr_data,
   output logic       dcdc_en,
   output logic       sys_reset_n,
   output logic       pwr_led,
   output logic [7:0] btn_status,
   output logic       btn_change
);
   import softpwr_pkg::*;

   if (TICK_DIV < 1)         begin : g_bad_div  $error("TICK_DIV must be at least 1"); end
   if (DEBOUNCE_TICKS < 1)   begin : g_bad_db   $error("DEBOUNCE_TICKS must be at least 1"); end
   if (RESET_HOLD_TICKS < 1) begin : g_bad_hold $error("RESET_HOLD_TICKS must be at least 1"); end
   if (LONG_PRESS_TICKS < 1) begin : g_bad_long $error("LONG_PRESS_TICKS must be at least 1"); end

   logic               tick;
   logic [NUM_BTN-1:0] raw_vec;
   logic [NUM_BTN-1:0] db_vec;
   logic               pwr_db, rst_db, pwr_prev;
   logic               press_rise, long_done, hold_run, hold_done;
   logic               supply_q, nreset_q;

   assign raw_vec[BTN_PWR] = pwr_btn_raw;
   assign raw_vec[BTN_RST] = rst_btn_raw;

   softpwr_tick #(.DIV(TICK_DIV)) i_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
      softpwr_debounce #(.TICKS(DEBOUNCE_TICKS)) i_db (
         .clk(clk), .rst_n(rst_n), .tick(tick),
         .raw(raw_vec[b]), .level(db_vec[b])
      );
   end

   assign pwr_db = db_vec[BTN_PWR];
   assign rst_db = db_vec[BTN_RST];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pwr_prev <= 1'b0;
      else        pwr_prev <= pwr_db;

   assign press_rise = pwr_db & ~pwr_prev;
   assign btn_change = pwr_db ^ pwr_prev;
   assign btn_status = {7'b0, pwr_db};

   softpwr_timer #(.LIMIT(LONG_PRESS_TICKS)) i_long (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(pwr_db), .done(long_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      supply_q <= 1'b0;
      else if (long_done)              supply_q <= 1'b0;
      else if (host_wr_en)             supply_q <= host_wr_data[0];
      else if (press_rise && !supply_q) supply_q <= 1'b1;
   end

   assign hold_run = supply_q & rails_good & ~rst_db;

   softpwr_timer #(.LIMIT(RESET_HOLD_TICKS)) i_hold (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(hold_run), .done(hold_done)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) nreset_q <= 1'b0;
      else        nreset_q <= hold_run & hold_done;

   assign dcdc_en     = supply_q;
   assign pwr_led     = supply_q;
   assign sys_reset_n = nreset_q;
endmodule

// File: rtl/softpwr_seq_chk.sv
module softpwr_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rails_good,
   input logic       host_wr_en,
   input logic [7:0] host_wr_data,
   input logic       dcdc_en,
   input logic       sys_reset_n,
   input logic       pwr_led,
   input logic [7:0] btn_status,
   input logic       btn_change
);
   assert_reset_follows_rails_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rails_good || !dcdc_en) |=> !sys_reset_n);

   assert_release_needs_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_reset_n) |-> ($past(rails_good) && $past(dcdc_en)));

   assert_host_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && !host_wr_data[0]) |=> !dcdc_en);

   assert_led_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_led == dcdc_en);

   assert_status_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
      btn_status[7:1] == 7'b0);

   assert_change_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      btn_change |-> (btn_status[0] != $past(btn_status[0])));
endmodule

bind softpwr_seq softpwr_seq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .rails_good(rails_good),
   .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
   .dcdc_en(dcdc_en), .sys_reset_n(sys_reset_n), .pwr_led(pwr_led),
   .btn_status(btn_status), .btn_change(btn_change)
);

// File: tb/test_softpwr_seq.sv
module test_softpwr_seq;
   localparam int DIV    = 4;
   localparam int DB     = 3;
   localparam int HOLD   = 5;
   localparam int LONG   = 20;
   localparam int SETTLE = (DB + 2) * DIV + 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_btn_raw = 1'b0, rst_btn_raw = 1'b0, rails_good = 1'b0;
   logic       host_wr_en = 1'b0;
   logic [7:0] host_wr_data = 8'h00;
   logic       dcdc_en, sys_reset_n, pwr_led, btn_change;
   logic [7:0] btn_status;

   int vectors = 0;
   int miscompares = 0;
   int chg_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   softpwr_seq #(
      .TICK_DIV(DIV), .DEBOUNCE_TICKS(DB),
      .RESET_HOLD_TICKS(HOLD), .LONG_PRESS_TICKS(LONG)
   ) i_softpwr_seq (
      .clk(clk), .rst_n(rst_n), .pwr_btn_raw(pwr_btn_raw),
      .rst_btn_raw(rst_btn_raw), .rails_good(rails_good),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .dcdc_en(dcdc_en), .sys_reset_n(sys_reset_n), .pwr_led(pwr_led),
      .btn_status(btn_status), .btn_change(btn_change)
   );

   always @(negedge clk) if (rst_n && btn_change) chg_cnt++;

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [7:0] d);
      host_wr_en = 1'b1;
      host_wr_data = d;
      cyc(1);
      host_wr_en = 1'b0;
   endtask

   function automatic logic exp_reset_low(input logic rails, input logic on);
      return !(rails && on);
   endfunction

   initial begin
      cyc(400000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      cyc(3);
      // R1: outputs held at zero during reset
      chk("R1 dcdc_en", dcdc_en, 0);
      chk("R1 sys_reset_n", sys_reset_n, 0);
      chk("R1 pwr_led", pwr_led, 0);
      chk("R1 btn_status", btn_status, 0);
      chk("R1 btn_change", btn_change, 0);
      rst_n = 1'b1;
      cyc(2);

      // R2: short glitch on the power button is filtered
      pwr_btn_raw = 1'b1; cyc(DIV); pwr_btn_raw = 1'b0;
      cyc(SETTLE);
      chk("R2 status after glitch", btn_status, 0);
      chk("R2 supply after glitch", dcdc_en, 0);
      chk("R2 no change event", chg_cnt, 0);

      // R3, R9, R10, R11: short press from off
      rails_good = 1'b1;
      pwr_btn_raw = 1'b1; cyc(SETTLE);
      chk("R9 status pressed", btn_status, 8'h01);
      chk("R10 one event on press", chg_cnt, 1);
      chk("R3 press turns supply on", dcdc_en, 1);
      chk("R11 led on", pwr_led, 1);
      pwr_btn_raw = 1'b0; cyc(SETTLE);
      chk("R9 status released", btn_status, 8'h00);
      chk("R10 one event on release", chg_cnt, 2);

      // R4, R7: host power down, reserved bits ignored
      host_write(8'h00); cyc(1);
      chk("R4 write zero powers down", dcdc_en, 0);
      chk("R7 reset low when off", sys_reset_n, 0);
      chk("R11 led off", pwr_led, 0);
      host_write(8'hFE); cyc(1);
      chk("R4 upper bits ignored", dcdc_en, 0);

      // R6: reset hold after power and rails good
      host_write(8'h01);
      chk("R4 write one powers up", dcdc_en, 1);
      cyc(14);
      chk("R6 reset held during hold time", sys_reset_n, 0);
      cyc(10);
      chk("R6 reset released after hold", sys_reset_n, 1);

      // R7: rails drop
      rails_good = 1'b0; cyc(1);
      chk("R7 reset on rails drop", sys_reset_n, 0);
      rails_good = 1'b1; cyc(25);
      chk("R6 released again", sys_reset_n, 1);

      // R8: reset button
      rst_btn_raw = 1'b1; cyc(SETTLE + 2);
      chk("R8 reset button asserts reset", sys_reset_n, 0);
      chk("R9 reset button not in status", btn_status, 8'h00);
      rst_btn_raw = 1'b0; cyc(8);
      chk("R8 reset still held after release", sys_reset_n, 0);
      cyc(37);
      chk("R8 reset released after hold", sys_reset_n, 1);

      // R5: long press forces off, host cannot override while held
      pwr_btn_raw = 1'b1; cyc(SETTLE + 40);
      chk("R5 still on before long window", dcdc_en, 1);
      cyc(50);
      chk("R5 long press forces off", dcdc_en, 0);
      host_write(8'h01); cyc(1);
      chk("R5 host write loses while held", dcdc_en, 0);
      pwr_btn_raw = 1'b0; cyc(SETTLE);
      chk("R5 stays off after release", dcdc_en, 0);
      pwr_btn_raw = 1'b1; cyc(SETTLE);
      chk("R3 short press after forced off", dcdc_en, 1);
      pwr_btn_raw = 1'b0; cyc(SETTLE);

      // Random host writes and rails changes
      for (int i = 0; i < 60; i++) begin
         logic [7:0] d;
         logic       r;
         int         w;
         d = 8'($urandom);
         r = ($urandom_range(0, 3) != 0);
         w = $urandom_range(3, 40);
         rails_good = r;
         host_write(d);
         cyc(w);
         chk("R4 random write", dcdc_en, d[0]);
         chk("R11 random led", pwr_led, d[0]);
         if (exp_reset_low(r, d[0]))
            chk("R7 random reset low", sys_reset_n, 0);
         else if (w >= 25)
            chk("R6 random reset released", sys_reset_n, 1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule